// File: doc/BRIEF.md
# Masked vector compare-subtract unit

This unit owns a small file of vector registers, each holding 64 integer elements, and a mask with one bit per element. A compare instruction tests every element of a source vector against one broadcast scalar and records the outcome in the mask. Later element-wise instructions, such as a subtract or a ramp fill, write back only those elements whose mask bit is set. A conditional statement inside a vector loop can then run as straight-line code, with no branch for each element.

An instruction is given by an operation code, a destination register index, a source register index and a 32-bit scalar, and it is presented with a one-cycle start strobe. The unit steps through the elements from index 0 upward, one element per clock. Each element that it writes back appears on a write trace made up of a valid flag, the element index and the new value. The mask is visible at all times. One cycle after the last element, the unit raises a done pulse, and a new instruction can be started in that same cycle.

Top module: `vec_cmpsub`

## Requirements
- R1: While reset (rstN low) is applied and right after it, busy and done are 0 and all 64 mask bits are 1.
- R2: A start seen while busy is 0 is accepted. Busy is then 1 for exactly 64 cycles. In the following cycle done is 1 for one cycle and busy is 0, and a start given in that cycle is accepted.
- R3: A start, opcode or register index presented while busy is 1 has no effect on the running instruction or on any later state.
- R4: Element i is handled in the i-th busy cycle, in ascending order from 0 to 63. wrIdx shows the index of the element being handled.
- R5: Opcode 1 (compare-not-equal) sets mask bit i to 1 when element i of the source register differs from the scalar, and clears it otherwise. It writes no element.
- R6: Opcode 0 (set-all) sets all 64 mask bits to 1 and writes no element.
- R7: Opcode 2 (subtract) writes destination element i with destination[i] minus source[i] wherever mask bit i is 1. The write shows on wrEn, wrIdx and wrData.
- R8: When mask bit i is 0, a subtract or fill leaves destination element i unchanged and wrEn stays 0 for that element.
- R9: Opcode 3 (ramp fill) writes destination element i with the scalar plus i wherever mask bit i is 1.
- R10: A subtract whose destination and source are the same register reads each element before it is written, so every unmasked element becomes 0.
- R11: All arithmetic is 32-bit two's-complement and wraps on overflow, for both subtract and fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Instruction strobe, taken when idle |
| opcode | input | 2 | 0 set-all, 1 compare-not-equal, 2 subtract, 3 ramp fill |
| dstSel | input | 2 | Destination register index |
| srcSel | input | 2 | Source register index |
| scalar | input | 32 | Broadcast scalar operand |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after the last element |
| wrEn | output | 1 | An element is written back this cycle |
| wrIdx | output | 6 | Index of the element being handled |
| wrData | output | 32 | Value being written back |
| maskBits | output | 64 | Current mask, bit i for element i |

## Verification
Two events can land in the same cycle: the retirement of one instruction and the acceptance of the next. The bench gives each new start in the very cycle in which it sees done. It then expects the following instruction's first element one cycle later, and its expected write queue has to drain exactly, with no gap and no stray write. A second collision happens inside a subtract whose destination is also its source, where element i is read and written back in the same cycle. The bench provokes this with matching register indices and expects zeros wherever the mask is set.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [1:0] {
    OP_SETALL = 2'd0,
    OP_CMPNE  = 2'd1,
    OP_SUB    = 2'd2,
    OP_FILL   = 2'd3
  } vcsOp_t;

  // per-cycle strobes from sequencer to datapath
  typedef struct packed {
    logic setMask;
    logic cmpMask;
    logic subVec;
    logic fillVec;
  } vcsStrobe_t;

endpackage

// File: rtl/vcs_ctrl.sv
module vcs_ctrl #(
  parameter int VLEN   = 64,
  parameter int ELEM_W = 32,
  parameter int RSEL_W = 2,
  localparam int IDX_W = $clog2(VLEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              opcode,
  input  logic [RSEL_W-1:0]       dstSel,
  input  logic [RSEL_W-1:0]       srcSel,
  input  logic [ELEM_W-1:0]       scalar,
  output logic                    busy,
  output logic                    done,
  output logic [IDX_W-1:0]        idx,
  output logic [RSEL_W-1:0]       dstQ,
  output logic [RSEL_W-1:0]       srcQ,
  output logic [ELEM_W-1:0]       scalarQ,
  output vcs_pkg::vcsStrobe_t     stb
);
  import vcs_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(VLEN - 1);

  vcsOp_t opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      opQ     <= OP_SETALL;
      dstQ    <= '0;
      srcQ    <= '0;
      scalarQ <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy    <= 1'b1;
        idx     <= '0;
        opQ     <= vcsOp_t'(opcode);
        dstQ    <= dstSel;
        srcQ    <= srcSel;
        scalarQ <= scalar;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.setMask = busy && (opQ == OP_SETALL);
    stb.cmpMask = busy && (opQ == OP_CMPNE);
    stb.subVec  = busy && (opQ == OP_SUB);
    stb.fillVec = busy && (opQ == OP_FILL);
  end

endmodule

// File: rtl/vcs_datapath.sv
module vcs_datapath #(
  parameter int VLEN   = 64,
  parameter int ELEM_W = 32,
  parameter int NREG   = 4,
  localparam int IDX_W  = $clog2(VLEN),
  localparam int RSEL_W = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rstN,
  input  vcs_pkg::vcsStrobe_t stb,
  input  logic [IDX_W-1:0]    idx,
  input  logic [RSEL_W-1:0]   dstSel,
  input  logic [RSEL_W-1:0]   srcSel,
  input  logic [ELEM_W-1:0]   scalar,
  output logic                wrEn,
  output logic [ELEM_W-1:0]   wrData,
  output logic [VLEN-1:0]     maskBits
);

  logic [ELEM_W-1:0] vrf [NREG][VLEN];
  logic [ELEM_W-1:0] dstElem, srcElem, diff, ramp;
  logic [VLEN-1:0]   maskNext;
  logic              cmpNe;

  assign dstElem = vrf[dstSel][idx];
  assign srcElem = vrf[srcSel][idx];
  assign diff    = dstElem - srcElem;
  assign ramp    = scalar + ELEM_W'(idx);
  assign cmpNe   = (srcElem != scalar);

  assign wrEn   = (stb.subVec || stb.fillVec) && maskBits[idx];
  assign wrData = stb.fillVec ? ramp : diff;

  // next-state of each mask bit
  for (genvar g = 0; g < VLEN; g++) begin : gMask
    logic hit;
    assign hit = (idx == IDX_W'(g));
    assign maskNext[g] = (hit && stb.setMask) ? 1'b1 :
                         (hit && stb.cmpMask) ? cmpNe : maskBits[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskBits <= '1;
    else       maskBits <= maskNext;
  end

  always_ff @(posedge clk) begin
    if (wrEn) vrf[dstSel][idx] <= wrData;
  end

endmodule

// File: rtl/vec_cmpsub.sv
module vec_cmpsub #(
  parameter int ELEM_W = 32,
  parameter int VLEN   = 64,
  parameter int NREG   = 4,
  localparam int IDX_W  = $clog2(VLEN),
  localparam int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic [RSEL_W-1:0] dstSel,
  input  logic [RSEL_W-1:0] srcSel,
  input  logic [ELEM_W-1:0] scalar,
  output logic              busy,
  output logic              done,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [ELEM_W-1:0] wrData,
  output logic [VLEN-1:0]   maskBits
);

  vcs_pkg::vcsStrobe_t stb;
  logic [RSEL_W-1:0]   dstQ, srcQ;
  logic [ELEM_W-1:0]   scalarQ;

  vcs_ctrl #(.VLEN(VLEN), .ELEM_W(ELEM_W), .RSEL_W(RSEL_W)) ctrlI (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dstSel(dstSel), .srcSel(srcSel), .scalar(scalar),
    .busy(busy), .done(done), .idx(wrIdx),
    .dstQ(dstQ), .srcQ(srcQ), .scalarQ(scalarQ), .stb(stb)
  );

  vcs_datapath #(.VLEN(VLEN), .ELEM_W(ELEM_W), .NREG(NREG)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(wrIdx),
    .dstSel(dstQ), .srcSel(srcQ), .scalar(scalarQ),
    .wrEn(wrEn), .wrData(wrData), .maskBits(maskBits)
  );

endmodule

// File: rtl/vcs_chk.sv
module vcs_chk #(
  parameter int VLEN = 64,
  localparam int IDX_W = $clog2(VLEN)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx,
  input logic [VLEN-1:0]  maskBits
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !(busy && wrIdx == '0));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (wrIdx == IDX_W'($past(wrIdx) + 1'b1)));

  // R8
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  // R5
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(maskBits));

endmodule

bind vec_cmpsub vcs_chk #(.VLEN(VLEN)) chkI (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .wrEn(wrEn), .wrIdx(wrIdx), .maskBits(maskBits)
);

// File: tb/vec_cmpsub_test.sv
`timescale 1ns/1ps
module vec_cmpsub_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opcode = 2'd0;
  logic [1:0]  dstSel = 2'd0;
  logic [1:0]  srcSel = 2'd0;
  logic [31:0] scalar = '0;
  logic        busy, done, wrEn;
  logic [5:0]  wrIdx;
  logic [31:0] wrData;
  logic [63:0] maskBits;

  always #2 clk = ~clk;

  vec_cmpsub uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dstSel(dstSel), .srcSel(srcSel), .scalar(scalar),
    .busy(busy), .done(done), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .maskBits(maskBits)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] data;
  } wrItem_t;

  wrItem_t     expQ[$];
  int          errors = 0;
  int          checks = 0;
  string       curReq = "R7";
  logic [31:0] mdl [4][64];
  logic [63:0] mMask = '1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected writes as the design produces them
  always @(negedge clk) begin
    wrItem_t e;
    if (rstN && wrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected write", {wrIdx, wrData}, 64'd0);
      end else begin
        e = expQ.pop_front();
        check(wrIdx == e.idx && wrData == e.data, curReq, "write (R4 order)",
              {26'd0, wrIdx, wrData}, {26'd0, e.idx, e.data});
      end
    end
  end

  // driver: model the instruction, queue its writes, run it, check timing
  task automatic runOp(input logic [1:0] op, input int d, input int s,
                       input logic [31:0] sc, input string req, input bit inject);
    curReq = req;
    for (int i = 0; i < 64; i++) begin
      case (op)
        2'd0: mMask[i] = 1'b1;
        2'd1: mMask[i] = (mdl[s][i] != sc);
        2'd2: if (mMask[i]) begin
                mdl[d][i] = mdl[d][i] - mdl[s][i];
                expQ.push_back({6'(i), mdl[d][i]});
              end
        default: if (mMask[i]) begin
                mdl[d][i] = sc + 32'(i);
                expQ.push_back({6'(i), mdl[d][i]});
              end
      endcase
    end
    opcode = op; dstSel = 2'(d); srcSel = 2'(s); scalar = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 64; c++) begin
      check(busy == 1'b1 && done == 1'b0, "R2", "busy during run", {busy, done}, 2'b10);
      if (inject && c == 10) begin
        start = 1'b1; opcode = 2'd2; dstSel = 2'd3; srcSel = 2'd0; scalar = '1;
      end else if (inject && c == 11) begin
        start = 1'b0; opcode = op; dstSel = 2'(d); srcSel = 2'(s); scalar = sc;
      end
      @(negedge clk);
    end
    check(done == 1'b1 && busy == 1'b0, "R2", "done pulse", {busy, done}, 2'b01);
    check(expQ.size() == 0, req, "missing writes", expQ.size(), 0);
    check(maskBits == mMask, req, "mask", maskBits, mMask);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R1", "status in reset", {busy, done}, 0);
    check(maskBits == '1, "R1", "mask in reset", maskBits, '1);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && maskBits == '1, "R1", "after reset",
          {busy, done, maskBits[61:0]}, {2'b00, 62'h3FFF_FFFF_FFFF_FFFF});
    // each op starts in the done cycle of the previous one (R2)
    runOp(2'd3, 0, 0, 32'd100,       "R9",  1'b0);
    runOp(2'd3, 1, 0, 32'hFFFF_FFE0, "R9",  1'b0);
    runOp(2'd1, 0, 1, 32'd0,         "R5",  1'b0);
    runOp(2'd3, 1, 0, 32'd7,         "R8",  1'b0);
    runOp(2'd1, 0, 1, 32'd20,        "R5",  1'b0);
    runOp(2'd2, 0, 1, 32'd0,         "R7",  1'b0);
    runOp(2'd0, 0, 0, 32'd0,         "R6",  1'b0);
    runOp(2'd3, 2, 0, 32'd5,         "R9",  1'b0);
    runOp(2'd2, 2, 2, 32'd0,         "R10", 1'b0);
    runOp(2'd2, 0, 2, 32'd0,         "R8",  1'b0);
    runOp(2'd3, 3, 0, 32'hFFFF_FFF0, "R11", 1'b0);
    runOp(2'd2, 3, 0, 32'd0,         "R11", 1'b0);
    runOp(2'd1, 0, 3, 32'hFFFF_FFF0, "R3",  1'b1);
    runOp(2'd2, 0, 2, 32'd0,         "R3",  1'b0);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R2", "idle at end", {busy, done}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule